// File: doc/BRIEF.md
# Parallel Scrambler and NRZI Codec

This block codes the word stream of a high-definition serial video link, handling a full 20-bit word each clock. In the transmit direction every word is scrambled by a self-synchronizing scrambler with polynomial x^9 + x^4 + 1. The result is then NRZI-coded (x + 1). Bit 0 is treated as the first bit on the wire, so the state steps through bits 0 to 19 in that order and carries over into the next word. In the receive direction an aligned 20-bit word is NRZI-decoded and then descrambled. The descrambler looks only at the last nine coded bits, so it locks onto any incoming stream without being seeded.

A coding enable selects between coded operation and transparent pass-through. A direction select chooses transmit or receive. A valid strobe marks the clocks that carry a word. The output is registered, with one clock of latency in every mode.

Top module: `nrzi_scr_codec`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` becomes 0 and the scrambler history (9 bits) and the NRZI bit are cleared to 0. As a consequence, coding the word 0 straight after reset yields 0, and coding the word 20'h00001 straight after reset yields 20'h2F10F.
- R2: With `dir_rx`=0 (transmit), `code_en`=1 and `vld_in`=1, the block processes each bit i from 0 to 19 in turn. It forms s = din[i] ^ s(9 bits earlier) ^ s(4 bits earlier), then sets dout[i] = s ^ (previous output bit). The state carries across words.
- R3: With `dir_rx`=1 (receive), `code_en`=1 and `vld_in`=1, the block processes each bit i from 0 to 19 in turn. It forms s = din[i] ^ (previous input bit), then sets dout[i] = s ^ s(9 bits earlier) ^ s(4 bits earlier). The state carries across words.
- R4: With `code_en`=0 and `vld_in`=1, `dout` equals `din` one clock later. The coding state is left unchanged, so coded words after a bypass stretch continue from the state held before it.
- R5: A valid word presented at a clock edge appears on `dout` right after that edge, in both coded and bypass modes.
- R6: With `vld_in`=0, `dout` and the coding state hold their values, whatever `din` and `code_en` are.
- R7: In receive mode, from the 11th received bit onwards (bit 10 of the first word), `dout` equals the original data whatever the state the decoder started in.
- R8: A transmit instance feeding a receive instance, which sees the same enable and valid one clock later, returns the original words two clocks after they were presented. This holds while the enable toggles between coded and bypass.
- R9: `dir_rx`=0 selects the transmit coder and `dir_rx`=1 selects the receive decoder. The same input gives different coded results in the two directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 20 | Input word, bit 0 first in serial order |
| vld_in | input | 1 | Word valid strobe |
| code_en | input | 1 | 1 = scramble/NRZI coding, 0 = pass-through |
| dir_rx | input | 1 | 0 = transmit coding, 1 = receive decoding |
| dout | output | 20 | Registered output word |

## Verification
The hardest case to reach is a decoder whose state does not match the stream it receives. Reset clears both ends alike, so a loopback started from reset is locked at once. To create the mismatch, the bench first runs the decoder on unrelated random words. It then feeds the decoder a stream coded by its own serial model, seeded with a nonzero history and NRZI bit. It checks that only the top ten bits of the first word are trusted and that every later word is exact. Bypass stretches that fall between coded words in the loopback show that the held state stays consistent at both ends.

// File: rtl/codec_pkg.sv
`timescale 1ns/1ps
package codec_pkg;

    localparam int CODEC_WORD = 20;
    localparam int CODEC_HIST = 9;
    localparam int CODEC_TAP  = 4;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } codec_dir_e;

    typedef struct packed {
        logic       coded;
        codec_dir_e dir;
    } codec_mode_t;

    // scrambler feedback: data bit with the far and near history taps
    function automatic logic scr_mix(input logic bit_in, input logic far_tap,
                                     input logic near_tap);
        return bit_in ^ far_tap ^ near_tap;
    endfunction

endpackage

// File: rtl/scr_tx_core.sv
`timescale 1ns/1ps
module scr_tx_core #(
    parameter int WORD_W  = 20,
    parameter int HIST_W  = 9,
    parameter int TAP_POS = 4
) (
    input  logic [WORD_W-1:0] plain,
    input  logic [HIST_W-1:0] hist_in,
    input  logic              nrzi_in,
    output logic [WORD_W-1:0] coded,
    output logic [HIST_W-1:0] hist_out,
    output logic              nrzi_out
);
    import codec_pkg::*;

    // unrolled serial walk, bit 0 first
    always_comb begin : walk
        logic [HIST_W-1:0] h;
        logic              p;
        logic              s;
        h     = hist_in;
        p     = nrzi_in;
        coded = '0;
        for (int i = 0; i < WORD_W; i++) begin
            s        = scr_mix(plain[i], h[HIST_W-1], h[TAP_POS-1]);
            h        = {h[HIST_W-2:0], s};
            p        = p ^ s;
            coded[i] = p;
        end
        hist_out = h;
        nrzi_out = p;
    end

endmodule

// File: rtl/scr_rx_core.sv
`timescale 1ns/1ps
module scr_rx_core #(
    parameter int WORD_W  = 20,
    parameter int HIST_W  = 9,
    parameter int TAP_POS = 4
) (
    input  logic [WORD_W-1:0] coded,
    input  logic [HIST_W-1:0] hist_in,
    input  logic              nrzi_in,
    output logic [WORD_W-1:0] plain,
    output logic [HIST_W-1:0] hist_out,
    output logic              nrzi_out
);
    import codec_pkg::*;

    // NRZI decode, then feed-forward descramble over received history
    always_comb begin : walk
        logic [HIST_W-1:0] h;
        logic              p;
        logic              s;
        h     = hist_in;
        p     = nrzi_in;
        plain = '0;
        for (int i = 0; i < WORD_W; i++) begin
            s        = coded[i] ^ p;
            p        = coded[i];
            plain[i] = scr_mix(s, h[HIST_W-1], h[TAP_POS-1]);
            h        = {h[HIST_W-2:0], s};
        end
        hist_out = h;
        nrzi_out = p;
    end

endmodule

// File: rtl/nrzi_scr_codec.sv
`timescale 1ns/1ps
module nrzi_scr_codec #(
    parameter int WORD_W  = codec_pkg::CODEC_WORD,
    parameter int HIST_W  = codec_pkg::CODEC_HIST,
    parameter int TAP_POS = codec_pkg::CODEC_TAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    input  logic              vld_in,
    input  logic              code_en,
    input  logic              dir_rx,
    output logic [WORD_W-1:0] dout
);
    import codec_pkg::*;

    generate
        if (TAP_POS < 1 || TAP_POS >= HIST_W) begin : g_bad_tap
            $error("TAP_POS must lie inside the history");
        end
    endgenerate

    codec_mode_t       mode;
    logic [HIST_W-1:0] hist_q;
    logic              nrzi_q;

    logic [WORD_W-1:0] tx_word, rx_word;
    logic [HIST_W-1:0] tx_hist, rx_hist;
    logic              tx_nrzi, rx_nrzi;

    logic [WORD_W-1:0] word_nx;
    logic [HIST_W-1:0] hist_nx;
    logic              nrzi_nx;

    assign mode.coded = code_en;
    assign mode.dir   = codec_dir_e'(dir_rx);

    scr_tx_core #(.WORD_W(WORD_W), .HIST_W(HIST_W), .TAP_POS(TAP_POS)) u_tx (
        .plain   (din),
        .hist_in (hist_q),
        .nrzi_in (nrzi_q),
        .coded   (tx_word),
        .hist_out(tx_hist),
        .nrzi_out(tx_nrzi)
    );

    scr_rx_core #(.WORD_W(WORD_W), .HIST_W(HIST_W), .TAP_POS(TAP_POS)) u_rx (
        .coded   (din),
        .hist_in (hist_q),
        .nrzi_in (nrzi_q),
        .plain   (rx_word),
        .hist_out(rx_hist),
        .nrzi_out(rx_nrzi)
    );

    always_comb begin
        word_nx = din;
        hist_nx = hist_q;
        nrzi_nx = nrzi_q;
        if (mode.coded) begin
            if (mode.dir == DIR_RX) begin
                word_nx = rx_word;
                hist_nx = rx_hist;
                nrzi_nx = rx_nrzi;
            end else begin
                word_nx = tx_word;
                hist_nx = tx_hist;
                nrzi_nx = tx_nrzi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            hist_q <= '0;
            nrzi_q <= 1'b0;
        end else if (vld_in) begin
            dout   <= word_nx;
            hist_q <= hist_nx;
            nrzi_q <= nrzi_nx;
        end
    end

endmodule

// File: rtl/codec_chk.sv
`timescale 1ns/1ps
module codec_chk #(
    parameter int WORD_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] din,
    input logic              vld_in,
    input logic              code_en,
    input logic              dir_rx,
    input logic [WORD_W-1:0] dout
);
    logic after_rst;
    always_ff @(posedge clk) after_rst <= rst;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        after_rst |-> dout == '0);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> $stable(dout));

    // R4
    bypass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_in && !code_en) |=> dout == $past(din));

    // R3
    rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_in && code_en && dir_rx && din == '0 &&
         $past(vld_in && code_en && dir_rx && din == '0)) |=> dout == '0);

endmodule

bind nrzi_scr_codec codec_chk #(.WORD_W(WORD_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .vld_in (vld_in),
    .code_en(code_en),
    .dir_rx (dir_rx),
    .dout   (dout)
);

// File: tb/sim_nrzi_scr_codec.sv
`timescale 1ns/1ps
module sim_nrzi_scr_codec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] a_din = '0;
    logic        a_en = 1'b0, a_vld = 1'b0, a_dir = 1'b0;
    logic        b_en = 1'b0, b_vld = 1'b0;
    logic [19:0] dout0, dout1;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    nrzi_scr_codec u0 (.clk(clk), .rst(rst), .din(a_din), .vld_in(a_vld),
                       .code_en(a_en), .dir_rx(a_dir), .dout(dout0));
    nrzi_scr_codec u1 (.clk(clk), .rst(rst), .din(dout0), .vld_in(b_vld),
                       .code_en(b_en), .dir_rx(1'b1), .dout(dout1));

    // {vld, en, din, expected dout after this word}, transmit from reset
    localparam int NTBL = 5;
    localparam logic [41:0] TBL [NTBL] = '{
        {1'b1, 1'b1, 20'h00000, 20'h00000},
        {1'b1, 1'b1, 20'h00001, 20'h2F10F},
        {1'b1, 1'b0, 20'hABCDE, 20'hABCDE},
        {1'b0, 1'b0, 20'h12345, 20'hABCDE},
        {1'b0, 1'b1, 20'h55555, 20'hABCDE}
    };

    logic [8:0] tm_h, rm_h;
    logic       tm_p, rm_p;

    task automatic tx_ref(input logic [19:0] d, output logic [19:0] y);
        logic s;
        for (int i = 0; i < 20; i++) begin
            s    = d[i] ^ tm_h[8] ^ tm_h[3];
            tm_h = {tm_h[7:0], s};
            tm_p = tm_p ^ s;
            y[i] = tm_p;
        end
    endtask

    task automatic rx_ref(input logic [19:0] y, output logic [19:0] d);
        logic s;
        for (int i = 0; i < 20; i++) begin
            s    = y[i] ^ rm_p;
            rm_p = y[i];
            d[i] = s ^ rm_h[8] ^ rm_h[3];
            rm_h = {rm_h[7:0], s};
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [19:0] act,
                       input logic [19:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // sample outputs at the negedge, then drive the next word; receiver
    // controls trail the transmitter controls by one word
    task automatic step(input logic [19:0] d, input logic e, input logic v,
                        output logic [19:0] o0, output logic [19:0] o1);
        @(negedge clk);
        o0    = dout0;
        o1    = dout1;
        b_en  = a_en;
        b_vld = a_vld;
        a_din = d;
        a_en  = e;
        a_vld = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; a_vld = 1'b0; b_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tm_h = '0; tm_p = 1'b0; rm_h = '0; rm_p = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [19:0] o0, o1, exp_m, y, d, hd1, hd2, w;
        logic        e, v, hv1, hv2;
        string       tag;

        // reset state, R1
        do_reset();
        @(negedge clk);
        chk(dout0 == 20'h0, "R1 reset dout tx", dout0, 20'h0);
        chk(dout1 == 20'h0, "R1 reset dout rx", dout1, 20'h0);

        // table walk, transmit: R1 R2 R4 R5 R6
        a_dir = 1'b0;
        exp_m = '0;
        for (int i = 0; i <= NTBL; i++) begin
            if (i < NTBL) step(TBL[i][39:20], TBL[i][40], TBL[i][41], o0, o1);
            else          step(20'h0, 1'b0, 1'b0, o0, o1);
            if (i > 0) begin
                chk(o0 == TBL[i-1][19:0], "R5 R1 R2 R4 R6 table word", o0, TBL[i-1][19:0]);
                chk(o0 == exp_m, "R2 table model", o0, exp_m);
            end
            if (i < NTBL && TBL[i][41]) begin
                if (TBL[i][40]) tx_ref(TBL[i][39:20], exp_m);
                else            exp_m = TBL[i][39:20];
            end
        end

        // random transmit mix of coded, bypass and idle words
        tag = "R2";
        for (int k = 0; k < 400; k++) begin
            d = 20'($urandom);
            e = ($urandom % 4) != 0;
            v = ($urandom % 5) != 0;
            step(d, e, v, o0, o1);
            chk(o0 == exp_m, tag, o0, exp_m);
            if (v) begin
                if (e) tx_ref(d, exp_m);
                else   exp_m = d;
                tag = e ? "R2 tx coded" : "R4 bypass";
            end else begin
                tag = "R6 idle hold";
            end
        end

        // receive direction: R3 R9
        do_reset();
        a_dir = 1'b1;
        exp_m = '0;
        tag = "R3";
        for (int k = 0; k < 300; k++) begin
            d = 20'($urandom);
            e = ($urandom % 4) != 0;
            v = ($urandom % 6) != 0;
            if (k < 4) begin e = 1'b1; v = 1'b1; end
            step(d, e, v, o0, o1);
            chk(o0 == exp_m, tag, o0, exp_m);
            if (v) begin
                if (e) rx_ref(d, exp_m);
                else   exp_m = d;
                tag = e ? "R3 R9 rx decode" : "R4 rx bypass";
            end else begin
                tag = "R6 rx idle";
            end
        end

        // self-synchronization from an unrelated state: R7
        tm_h = 9'h1A5; tm_p = 1'b1;
        hd1 = '0;
        for (int k = 0; k < 40; k++) begin
            d = 20'($urandom);
            tx_ref(d, y);
            step(y, 1'b1, 1'b1, o0, o1);
            if (k == 1)
                chk(o0[19:10] == hd1[19:10], "R7 first word upper bits",
                    {10'h0, o0[19:10]}, {10'h0, hd1[19:10]});
            else if (k > 1)
                chk(o0 == hd1, "R7 settled word", o0, hd1);
            hd1 = d;
        end

        // loopback transmit into receive with enable toggles: R8
        do_reset();
        a_dir = 1'b0;
        e = 1'b1;
        hd1 = '0; hd2 = '0; hv1 = 1'b0; hv2 = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 8) == 0) e = ~e;
            v = ($urandom % 8) != 0;
            w = 20'($urandom);
            step(w, e, v, o0, o1);
            if (k >= 4 && hv2) chk(o1 == hd2, "R8 loopback", o1, hd2);
            hd2 = hd1; hv2 = hv1;
            hd1 = w;   hv1 = v;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule